// File: doc/BRIEF.md
# Real-Time Tick Counter with Dual Alarm Compare

This block is a memory-mapped real-time clock. It divides its input clock (nominally 32.768 kHz) by a programmable amount to make a tick. Each tick advances a 32-bit time counter. Two compare registers watch the counter. When the counter steps onto a programmed value and the matching alarm is enabled, a sticky flag is raised. A third sticky flag records every tick.

All three flags sit in one status word next to their enable bits. Software clears a flag by writing 1 to it, while the enable bits are plain read/write. The interrupt line is high whenever any flag is set together with its enable.

The counter only runs while the clock-select register holds the run code. A scratch word keeps its contents through a block reset, so software can keep a wrap count there across a reboot. Access is through a single-cycle write strobe and a combinational read data path, synchronous to the block clock.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the counter, both alarm registers, the divider, the clock-select register and the status word all read 0, and irq is low.
- R2: A write to the counter (offset 0x00) or to the divider (offset 0x0C) restarts the prescaler. The counter then first steps by one 2×(DIV+1) clock edges after the landing edge of that write, and again every 2×(DIV+1) edges after that.
- R3: The counter advances only while the clock-select register (offset 0x1C, 2 bits) holds 3. Any other value holds the counter still.
- R4: The counter wraps from 0xFFFFFFFF to 0 on the next step.
- R5: The counter (0x00), alarm0 (0x04), divider (0x0C, 16 bits), alarm1 (0x18) and clock-select (0x1C) registers read back what was last written. A counter write loads a new time.
- R6: Status bit 0, the alarm0 flag, is set one edge after the counter steps onto the alarm0 value, and only if bit 2 (alarm0 enable) is 1. Loading the counter by a write never sets it.
- R7: Status bit 4, the alarm1 flag, is set one edge after the counter steps onto the alarm1 value, and only if bit 6 (alarm1 enable) is 1.
- R8: Status bit 1, the tick flag, is set one edge after every counter step, whatever its enable (bit 3) holds.
- R9: Writing the status word (0x08) clears each flag bit (0, 1, 4) written with 1 and leaves each flag written with 0 unchanged. The enable bits 2, 3 and 6 take the written value.
- R10: If a write-1 clear lands on the same edge that sets the flag, the flag ends up set.
- R11: irq is high exactly when at least one flag is set together with its enable (bit 0 with 2, bit 1 with 3, bit 4 with 6). A flag with its enable cleared still reads as 1 but does not drive irq.
- R12: Status bits 5 and 7 to 31 always read 0.
- R13: The scratch word at 0x40 reads back what was written, and a block reset does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the time base that is divided |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the register accessed |
| busWrite | input | 1 | Write strobe; the write lands on the next rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
A register write lands on the rising edge after busWrite is seen, and its effect can be read back at the next falling edge. A counter step comes 2×(DIV+1) edges after the landing edge of a counter write. Each flag rises one edge later than the counter step that caused it, and irq follows the flag and enable registers with no extra delay. The bench drives writes and samples reads only on falling edges, and counts edges from the landing edge of the last counter write. For every flag it checks both the cycle just before the set and the cycle of the set. A clear is timed to land on the same edge as a set to check that the set wins.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Register byte offsets
  localparam int OFS_CNT  = 'h00;
  localparam int OFS_AL0  = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_DIV  = 'h0C;
  localparam int OFS_AL1  = 'h18;
  localparam int OFS_SEL  = 'h1C;
  localparam int OFS_SCR  = 'h40;

  // Status word bit positions
  localparam int B_FAL0  = 0;
  localparam int B_FTICK = 1;
  localparam int B_EAL0  = 2;
  localparam int B_ETICK = 3;
  localparam int B_FAL1  = 4;
  localparam int B_EAL1  = 6;

  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_RUN = 2'b11;

  typedef struct packed {
    logic wrCnt;
    logic wrAl0;
    logic wrAl1;
    logic wrStat;
    logic wrDiv;
    logic wrSel;
    logic wrScr;
    logic tick;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              clkRun,
  output rtcStrobe_t        strb
);
  localparam int PRE_W = DIV_W + 1;

  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] preLim;
  rtcStrobe_t       dec;

  // Terminal count 2*DIV+1 gives 2*(DIV+1) edges per tick
  assign preLim = {divVal, 1'b1};

  always_comb begin
    dec = '0;
    if (busWrite) begin
      case (busAddr)
        ADDR_W'(OFS_CNT):  dec.wrCnt  = 1'b1;
        ADDR_W'(OFS_AL0):  dec.wrAl0  = 1'b1;
        ADDR_W'(OFS_AL1):  dec.wrAl1  = 1'b1;
        ADDR_W'(OFS_STAT): dec.wrStat = 1'b1;
        ADDR_W'(OFS_DIV):  dec.wrDiv  = 1'b1;
        ADDR_W'(OFS_SEL):  dec.wrSel  = 1'b1;
        ADDR_W'(OFS_SCR):  dec.wrScr  = 1'b1;
        default: ;
      endcase
    end
    dec.tick = clkRun && (preQ == preLim) && !(dec.wrCnt || dec.wrDiv);
  end

  assign strb = dec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (!clkRun || dec.wrCnt || dec.wrDiv || (preQ == preLim)) begin
      preQ <= '0;
    end else begin
      preQ <= preQ + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DIV_W-1:0]  divVal,
  output logic              clkRun,
  output logic              irq
);
  logic [DATA_W-1:0] cntQ, al0Q, al1Q, scrQ, cntNext, statVec;
  logic [DIV_W-1:0]  divQ;
  logic [SEL_W-1:0]  selQ;
  logic fAl0, fTick, fAl1, eAl0, eTick, eAl1;
  logic hitAl0Q, hitAl1Q, stepQ;
  logic clrAl0, clrTick, clrAl1;

  assign cntNext = cntQ + 1'b1;
  assign divVal  = divQ;
  assign clkRun  = (selQ == SEL_RUN);

  assign clrAl0  = strb.wrStat && busWdata[B_FAL0];
  assign clrTick = strb.wrStat && busWdata[B_FTICK];
  assign clrAl1  = strb.wrStat && busWdata[B_FAL1];

  // Configuration and time registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      al0Q <= '0;
      al1Q <= '0;
      divQ <= '0;
      selQ <= '0;
    end else begin
      if (strb.wrCnt)      cntQ <= busWdata;
      else if (strb.tick)  cntQ <= cntNext;
      if (strb.wrAl0) al0Q <= busWdata;
      if (strb.wrAl1) al1Q <= busWdata;
      if (strb.wrDiv) divQ <= busWdata[DIV_W-1:0];
      if (strb.wrSel) selQ <= busWdata[SEL_W-1:0];
    end
  end

  // Scratch word survives the block reset
  always_ff @(posedge clk) begin
    if (strb.wrScr) scrQ <= busWdata;
  end

  // Compare on the post-increment value, registered one stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitAl0Q <= 1'b0;
      hitAl1Q <= 1'b0;
      stepQ   <= 1'b0;
    end else begin
      hitAl0Q <= strb.tick && eAl0 && (cntNext == al0Q);
      hitAl1Q <= strb.tick && eAl1 && (cntNext == al1Q);
      stepQ   <= strb.tick;
    end
  end

  // Status: sticky flags (set wins over clear) and plain enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fAl0  <= 1'b0;
      fTick <= 1'b0;
      fAl1  <= 1'b0;
      eAl0  <= 1'b0;
      eTick <= 1'b0;
      eAl1  <= 1'b0;
    end else begin
      if (hitAl0Q)     fAl0 <= 1'b1;
      else if (clrAl0) fAl0 <= 1'b0;
      if (stepQ)        fTick <= 1'b1;
      else if (clrTick) fTick <= 1'b0;
      if (hitAl1Q)     fAl1 <= 1'b1;
      else if (clrAl1) fAl1 <= 1'b0;
      if (strb.wrStat) begin
        eAl0  <= busWdata[B_EAL0];
        eTick <= busWdata[B_ETICK];
        eAl1  <= busWdata[B_EAL1];
      end
    end
  end

  assign irq = (fAl0 && eAl0) || (fTick && eTick) || (fAl1 && eAl1);

  always_comb begin
    statVec          = '0;
    statVec[B_FAL0]  = fAl0;
    statVec[B_FTICK] = fTick;
    statVec[B_EAL0]  = eAl0;
    statVec[B_ETICK] = eTick;
    statVec[B_FAL1]  = fAl1;
    statVec[B_EAL1]  = eAl1;
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(OFS_CNT):  busRdata = cntQ;
      ADDR_W'(OFS_AL0):  busRdata = al0Q;
      ADDR_W'(OFS_AL1):  busRdata = al1Q;
      ADDR_W'(OFS_STAT): busRdata = statVec;
      ADDR_W'(OFS_DIV):  busRdata = DATA_W'(divQ);
      ADDR_W'(OFS_SEL):  busRdata = DATA_W'(selQ);
      ADDR_W'(OFS_SCR):  busRdata = scrQ;
      default:           busRdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  rtcStrobe_t       strb;
  logic [DIV_W-1:0] divVal;
  logic             clkRun;

  rtc_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .divVal(divVal), .clkRun(clkRun), .strb(strb)
  );

  rtc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .divVal(divVal),
    .clkRun(clkRun), .irq(irq)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busWrite,
  input logic       irq,
  input rtcStrobe_t strb,
  input logic       clkRun
);
  // R3: no tick unless the run code is selected
  p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    !clkRun |-> !strb.tick);

  // R2: minimum period is two edges
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> !strb.tick);

  // R2: a counter load restarts the prescaler
  p_load_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCnt |=> !strb.tick);

  // R6: irq rises only from a step two edges back or a status write
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(strb.tick, 2) || $past(busWrite)));

  // R9: irq drops only because software wrote something
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(busWrite));
endmodule

bind rtc_alarm_timer rtc_checker uChk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .irq(irq),
  .strb(strb), .clkRun(clkRun)
);

// File: tb/sim_rtc_alarm_timer.sv
`timescale 1ns/1ps
module sim_rtc_alarm_timer;
  localparam logic [7:0] A_CNT = 8'h00, A_AL0 = 8'h04, A_STAT = 8'h08,
                         A_DIV = 8'h0C, A_AL1 = 8'h18, A_SEL = 8'h1C,
                         A_SCR = 8'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic halt();
    wr(A_SEL, 32'd0);
  endtask

  // run code then counter load: landing edge of the load is the reference
  task automatic start(input logic [31:0] c);
    wr(A_SEL, 32'd3);
    wr(A_CNT, c);
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(A_CNT, v);  chk("R1 counter", v, 0);
    rd(A_AL0, v);  chk("R1 alarm0", v, 0);
    rd(A_AL1, v);  chk("R1 alarm1", v, 0);
    rd(A_DIV, v);  chk("R1 divider", v, 0);
    rd(A_SEL, v);  chk("R1 select", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic tHold();
    logic [31:0] v;
    wr(A_CNT, 32'd5);
    idle(20);
    rd(A_CNT, v); chk("R3 held at select 0", v, 5);
    wr(A_SEL, 32'd2);
    idle(12);
    rd(A_CNT, v); chk("R3 held at select 2", v, 5);
    rd(A_SEL, v); chk("R5 select readback", v, 2);
  endtask

  task automatic tRate();
    logic [31:0] v;
    wr(A_SEL, 32'd3);
    wr(A_DIV, 32'd3);
    wr(A_CNT, 32'd100);
    idle(7);
    rd(A_CNT, v); chk("R2 before first step", v, 100);
    idle(1);
    rd(A_CNT, v); chk("R2 first step", v, 101);
    idle(7);
    rd(A_CNT, v); chk("R2 before second step", v, 101);
    idle(1);
    rd(A_CNT, v); chk("R2 second step", v, 102);
    rd(A_DIV, v); chk("R5 divider readback", v, 3);
    halt();
  endtask

  task automatic tWrap();
    logic [31:0] v;
    halt();
    wr(A_DIV, 32'd0);
    wr(A_STAT, 32'h13);
    start(32'hFFFF_FFFF);
    idle(1);
    rd(A_CNT, v);  chk("R4 top value", v, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R8 tick flag not yet", v & 32'h2, 0);
    idle(1);
    rd(A_CNT, v);  chk("R4 wrapped", v, 0);
    rd(A_STAT, v); chk("R8 tick flag one edge late", v & 32'h2, 0);
    idle(1);
    rd(A_STAT, v); chk("R8 tick flag set", v & 32'h2, 32'h2);
    chk("R11 tick without enable", {31'd0, irq}, 0);
    halt();
  endtask

  task automatic tAlarm0();
    logic [31:0] v;
    halt();
    wr(A_DIV, 32'd0);
    wr(A_AL0, 32'd200);
    wr(A_STAT, 32'h17);
    start(32'd198);
    idle(4);
    rd(A_CNT, v);  chk("R6 counter at alarm", v, 200);
    rd(A_STAT, v); chk("R6 flag not yet", v & 32'h1, 0);
    idle(1);
    rd(A_STAT, v); chk("R6 alarm0 flag set", v & 32'h1, 1);
    chk("R11 irq from alarm0", {31'd0, irq}, 1);
    rd(A_AL0, v);  chk("R5 alarm0 readback", v, 200);
    halt();
    wr(A_STAT, 32'h00);
    rd(A_STAT, v); chk("R11 flag kept, enables off", v & 32'h4D, 32'h01);
    chk("R11 masked irq", {31'd0, irq}, 0);
    wr(A_STAT, 32'h04);
    chk("R11 irq on re-enable", {31'd0, irq}, 1);
    wr(A_STAT, 32'h05);
    rd(A_STAT, v); chk("R9 clear only bit0", v & 32'h7, 32'h6);
    chk("R9 irq after clear", {31'd0, irq}, 0);
    wr(A_STAT, 32'h13);
    rd(A_STAT, v); chk("R9 all cleared", v, 0);
    wr(A_STAT, 32'h04);
    wr(A_CNT, 32'd200);
    idle(3);
    rd(A_STAT, v); chk("R6 load does not match", v & 32'h1, 0);
    wr(A_STAT, 32'h00);
  endtask

  task automatic tDisabled();
    logic [31:0] v;
    halt();
    wr(A_AL0, 32'd50);
    wr(A_STAT, 32'h13);
    start(32'd48);
    idle(8);
    rd(A_CNT, v);  chk("R2 divider 0 period", v, 52);
    rd(A_STAT, v); chk("R6 disabled no flag", v & 32'h1, 0);
    chk("R6 disabled no irq", {31'd0, irq}, 0);
    halt();
  endtask

  task automatic tCollide();
    logic [31:0] v;
    halt();
    wr(A_AL0, 32'd300);
    wr(A_STAT, 32'h17);
    start(32'd299);
    idle(1);
    wr(A_STAT, 32'h05);
    rd(A_STAT, v); chk("R10 set beats clear", v & 32'h1, 1);
    wr(A_STAT, 32'h05);
    rd(A_STAT, v); chk("R9 later clear works", v & 32'h1, 0);
    halt();
    wr(A_STAT, 32'h13);
  endtask

  task automatic tAlarm1();
    logic [31:0] v;
    halt();
    wr(A_AL1, 32'h1234);
    wr(A_STAT, 32'h53);
    start(32'h1232);
    idle(4);
    rd(A_STAT, v); chk("R7 flag not yet", v & 32'h10, 0);
    idle(1);
    rd(A_STAT, v); chk("R7 alarm1 flag set", v & 32'h11, 32'h10);
    chk("R11 irq from alarm1", {31'd0, irq}, 1);
    rd(A_AL1, v);  chk("R5 alarm1 readback", v, 32'h1234);
    halt();
    wr(A_STAT, 32'h50);
    rd(A_STAT, v); chk("R9 alarm1 cleared", v & 32'h10, 0);
    chk("R9 irq after alarm1 clear", {31'd0, irq}, 0);
  endtask

  task automatic tTick();
    logic [31:0] v;
    halt();
    wr(A_DIV, 32'd1);
    wr(A_STAT, 32'h1B);
    start(32'd7);
    idle(4);
    rd(A_CNT, v);  chk("R2 divider 1 period", v, 8);
    rd(A_STAT, v); chk("R8 tick flag not yet", v & 32'h2, 0);
    chk("R11 no irq yet", {31'd0, irq}, 0);
    idle(1);
    rd(A_STAT, v); chk("R8 tick flag", v & 32'h2, 32'h2);
    chk("R11 irq from tick", {31'd0, irq}, 1);
    halt();
    wr(A_STAT, 32'h0A);
    rd(A_STAT, v); chk("R9 tick flag cleared", v & 32'h2, 0);
    chk("R9 irq after tick clear", {31'd0, irq}, 0);
  endtask

  task automatic tUnused();
    logic [31:0] v;
    halt();
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R12 unused bits zero", v, 32'h4C);
    chk("R12 irq", {31'd0, irq}, 0);
    wr(A_STAT, 32'h13);
  endtask

  task automatic tScratch();
    logic [31:0] v;
    wr(A_SCR, 32'hA5A5_1234);
    rd(A_SCR, v); chk("R13 scratch readback", v, 32'hA5A5_1234);
    wr(A_CNT, 32'd77);
    @(negedge clk); rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
    rd(A_SCR, v); chk("R13 scratch kept over reset", v, 32'hA5A5_1234);
    rd(A_CNT, v); chk("R1 counter after second reset", v, 0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    tReset();
    tHold();
    tRate();
    tWrap();
    tAlarm0();
    tDisabled();
    tCollide();
    tAlarm1();
    tTick();
    tUnused();
    tScratch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule